// File: doc/BRIEF.md
# Comparator Output Conditioning and Change Interrupt

This block is the digital back end that sits behind an analog voltage comparator. It receives a single raw decision bit, which is 1 when the positive input is above the negative input and 0 when it is below. An optional inversion is applied to that bit. The result either passes straight through or is re-timed on the falling edge of a timer clock. The conditioned value drives an output-pin signal and a timer count-enable signal.

A four-phase sequencer running on the oscillator clock times a status-capture register and a read-path reference register. The capture register is loaded in the first phase and is what a status read returns. The reference register is loaded in the third phase of a status read. Whenever the two disagree, a sticky interrupt flag is set, and it stays set until software clears it.

In sleep the phase sequencer stops and the capture register loads on every oscillator edge. An output change therefore still sets the flag, and the flag raises a wake-up output. No data stream passes through the block, so it has no valid/ready handshake. Every port is a plain level or strobe, sampled on the rising oscillator edge unless stated otherwise.

Top module: `cmp_out_cond`

## Requirements
- R1: While rst_n is low, irq_flag, status_bit and wake are 0, the timer-resync register holds 0, and the phase sequencer sits at phase Q1.
- R2: With sync_sel = 0, pin_out and gate_en both equal raw_cmp XOR pol_inv, combinationally and without any clock.
- R3: With sync_sel = 1, pin_out and gate_en show the value of raw_cmp XOR pol_inv captured at the most recent falling edge of tmr_clk, and they hold that value between falling edges.
- R4: The phase sequencer is a 2-bit count with encoding 0 = Q1, 1 = Q2, 2 = Q3, 3 = Q4. On each rising clk edge with sleep = 0 it advances by one and wraps from Q4 to Q1. With sleep = 1 it holds its value. After reset release, the first rising edge sees Q1.
- R5: status_bit loads the conditioned output on a rising clk edge at which the phase is Q1, and it holds its value on every other edge while sleep = 0.
- R6: A status read is status_rd = 1 at a rising edge where the phase is Q3. It copies status_bit into the read reference. irq_flag is set on any rising edge at which status_bit and the read reference differ.
- R7: irq_flag stays set until flag_clr = 1 at a rising edge. If the set condition of R6 holds at that same edge, the flag stays set.
- R8: With sleep = 1, status_bit loads the conditioned output on every rising clk edge.
- R9: wake equals sleep AND irq_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; phase sequencer and flag logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_cmp | input | 1 | Raw comparator decision, 1 = positive input higher |
| pol_inv | input | 1 | Invert the raw decision when 1 |
| sync_sel | input | 1 | 1 selects the timer-resynchronised output |
| tmr_clk | input | 1 | Timer clock source; falling edge loads the resync register |
| sleep | input | 1 | Device sleep state |
| status_rd | input | 1 | Status read strobe, effective in phase Q3 |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| pin_out | output | 1 | Conditioned output for the pin |
| gate_en | output | 1 | Conditioned output used as timer count enable |
| status_bit | output | 1 | Captured value returned by a status read |
| irq_flag | output | 1 | Sticky change-interrupt flag |
| wake | output | 1 | Wake-up request while sleeping |

## Verification
The embedded properties check on every cycle that the sequencer advances or freezes correctly around sleep, that the capture register holds outside its phase and follows the output on each sleeping edge, and that the flag sets after a mismatch and stays set until a clear. Other behaviour shows up only in the bench scenarios, which sweep every polarity and resync setting against sequences of raw values, timer edges, reads, clears and sleep entries. These scenarios are needed to show the exact cycle in which the flag rises after a change, that a read taken outside Q3 is ignored, and that a clear arriving together with a mismatch loses.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam phase_e CAPTURE_PHASE = PH_Q1;
  localparam phase_e READ_PHASE    = PH_Q3;
endpackage

// File: rtl/cmp_polsync.sv
module cmp_polsync #(
  parameter bit SYNC_EN = 1'b1
) (
  input  logic rst_n,
  input  logic raw_cmp,
  input  logic pol_inv,
  input  logic sync_sel,
  input  logic tmr_clk,
  output logic cond
);
  logic adj;
  assign adj = raw_cmp ^ pol_inv;

  generate
    if (SYNC_EN) begin : g_sync
      logic resync_q;
      always_ff @(negedge tmr_clk or negedge rst_n) begin
        if (!rst_n) resync_q <= 1'b0;
        else        resync_q <= adj;
      end
      assign cond = sync_sel ? resync_q : adj;
    end else begin : g_nosync
      logic unused_sync;
      assign unused_sync = sync_sel ^ tmr_clk;
      assign cond = adj;
    end
  endgenerate
endmodule

// File: rtl/cmp_phase_gen.sv
module cmp_phase_gen
  import cmp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  output phase_e phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= PH_Q1;
    else if (!hold) phase <= phase_e'(phase + 2'd1);
  end

  // R4
  freeze_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> phase == $past(phase));

  // R4
  advance_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> phase == phase_e'($past(phase) + 2'd1));
endmodule

// File: rtl/cmp_chg_detect.sv
module cmp_chg_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic cap_en,
  input  logic rd_en,
  input  logic clr,
  output logic cap_q,
  output logic flag_q
);
  logic ref_q;
  logic mismatch;

  assign mismatch = cap_q ^ ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cap_en) cap_q <= cond;
      if (rd_en)  ref_q <= cap_q;
      flag_q <= mismatch | (flag_q & ~clr);
    end
  end

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_q));

  // R6
  mismatch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != ref_q) |=> flag_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmp_pkg::*;
#(
  parameter bit SYNC_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_cmp,
  input  logic pol_inv,
  input  logic sync_sel,
  input  logic tmr_clk,
  input  logic sleep,
  input  logic status_rd,
  input  logic flag_clr,
  output logic pin_out,
  output logic gate_en,
  output logic status_bit,
  output logic irq_flag,
  output logic wake
);
  logic   cond;
  phase_e phase;
  logic   cap_en;
  logic   rd_en;

  cmp_polsync #(.SYNC_EN(SYNC_EN)) u_polsync (
    .rst_n    (rst_n),
    .raw_cmp  (raw_cmp),
    .pol_inv  (pol_inv),
    .sync_sel (sync_sel),
    .tmr_clk  (tmr_clk),
    .cond     (cond)
  );

  cmp_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (sleep),
    .phase (phase)
  );

  assign cap_en = sleep | (phase == CAPTURE_PHASE);
  assign rd_en  = status_rd & (phase == READ_PHASE);

  cmp_chg_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (cond),
    .cap_en (cap_en),
    .rd_en  (rd_en),
    .clr    (flag_clr),
    .cap_q  (status_bit),
    .flag_q (irq_flag)
  );

  assign pin_out = cond;
  assign gate_en = cond;
  assign wake    = sleep & irq_flag;

  // R8
  sleep_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> status_bit == $past(cond));
endmodule

// File: tb/cmp_out_cond_bench.sv
`timescale 1ns/1ps
module cmp_out_cond_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_cmp = 1'b0, pol_inv = 1'b0, sync_sel = 1'b0, tmr_clk = 1'b1;
  logic sleep = 1'b0, status_rd = 1'b0, flag_clr = 1'b0;
  logic pin_out, gate_en, status_bit, irq_flag, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_out_cond u_cmp_out_cond (
    .clk(clk), .rst_n(rst_n), .raw_cmp(raw_cmp), .pol_inv(pol_inv),
    .sync_sel(sync_sel), .tmr_clk(tmr_clk), .sleep(sleep),
    .status_rd(status_rd), .flag_clr(flag_clr), .pin_out(pin_out),
    .gate_en(gate_en), .status_bit(status_bit), .irq_flag(irq_flag),
    .wake(wake)
  );

  // Reference model, written from the requirements
  int m_ph;
  bit m_cap, m_ref, m_flag, m_sync;

  always @(negedge tmr_clk or negedge rst_n) begin
    if (!rst_n) m_sync = 1'b0;
    else        m_sync = raw_cmp ^ pol_inv;
  end

  function automatic bit exp_out();
    return sync_sel ? m_sync : (raw_cmp ^ pol_inv);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cap = 0; m_ref = 0; m_flag = 0;
    end else begin
      bit set_now, nflag;
      set_now = (m_cap != m_ref);
      nflag   = set_now || (m_flag && !flag_clr);
      if (status_rd && m_ph == 2) m_ref = m_cap;
      if (sleep || m_ph == 0)     m_cap = exp_out();
      if (!sleep)                 m_ph = (m_ph + 1) % 4;
      m_flag = nflag;
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    check(sync_sel ? "R3" : "R2", "pin_out", pin_out, exp_out());
    check(sync_sel ? "R3" : "R2", "gate_en", gate_en, exp_out());
    check(sleep ? "R8" : "R4/R5", "status_bit", status_bit, m_cap);
    check("R6/R7", "irq_flag", irq_flag, m_flag);
    check("R9", "wake", wake, sleep & m_flag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "irq_flag", irq_flag, 1'b0);
    check("R1", "status_bit", status_bit, 1'b0);
    check("R1", "wake", wake, 1'b0);
    if (sync_sel) check("R1", "resync pin_out", pin_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(bit r, bit rd, bit cl, bit sl, bit tc);
    @(negedge clk);
    raw_cmp = r; status_rd = rd; flag_clr = cl; sleep = sl;
    #0.5 tmr_clk = tc;
    #0.5 check_all();
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      pol_inv  = cfg[0];
      sync_sel = cfg[1];
      sleep = 0; status_rd = 0; flag_clr = 0; tmr_clk = 1;
      raw_cmp = 1;
      do_reset();
      for (int sl = 0; sl < 2; sl++) begin
        for (int pat = 0; pat < 128; pat++) begin
          step(pat[0] ^ pat[3], pat[1], pat[2] & pat[4],
               sl[0] & pat[5], pat[2] ^ pat[6]);
        end
      end
      // hold a changed value with clears pending: set wins over clear (R7)
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 12; k++) step(k[2], 1'b0, 1'b1, 1'b0, k[0]);
      // reads every cycle then clear: flag must drop (R6, R7)
      for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule